// File: doc/BRIEF.md
# Byte Shift and Rotate Unit

A purely combinational datapath slice that moves the bits of a byte operand left or right by a small literal distance. A 2-bit function code picks one of four operations: logical shift left, logical shift right, rotate left and rotate right. The distance is a 3-bit literal, so any count from 0 to 7 is possible. Alongside the moved byte the unit produces the next values of a zero flag and a carry flag, ready for a condition-code register elsewhere in the core to capture.

The carry flag reports the last bit that crossed the edge of the byte while the operand was being moved. For shifts that bit is lost from the result; for rotates it reappears at the opposite end. A count of zero moves nothing, so the operand passes through and the carry is cleared. The unit has no clock, no state and no handshake: the owning pipeline stage presents the operand, code and count and samples the three outputs in the same cycle.

Top module: `shrot_unit`

## Requirements
- R1: With function code 00 (shift left) and count n, the result is the operand moved n places towards bit 7, with bits below position n filled with 0.
- R2: With function code 01 (shift right) and count n, the result is the operand moved n places towards bit 0, with the top n bit positions filled with 0.
- R3: With function code 10 (rotate left) and count n, result bit (i+n) mod 8 equals operand bit i for every i.
- R4: With function code 11 (rotate right) and count n, result bit i equals operand bit (i+n) mod 8 for every i.
- R5: For every function code, a count of 0 gives a result equal to the operand and a carry output of 0.
- R6: The zero output is 1 exactly when all 8 result bits are 0.
- R7: For a shift with count n from 1 to 7, the carry output is operand bit 8-n for a left shift and operand bit n-1 for a right shift.
- R8: For a rotate with count n from 1 to 7, the carry output is operand bit 8-n for rotate left and operand bit n-1 for rotate right; it therefore equals result bit 0 after rotate left and result bit 7 after rotate right.
- R9: A left shift by 3 yields the operand times 8 modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | DATA_W (8) | Byte to be shifted or rotated |
| func_i | input | 2 | Operation select: 00 shift left, 01 shift right, 10 rotate left, 11 rotate right |
| count_i | input | CNT_W (3) | Literal distance, 0 to 7 |
| result_o | output | DATA_W (8) | Moved byte |
| zero_o | output | 1 | Next zero flag: result is all zeros |
| carry_o | output | 1 | Next carry flag: last bit moved past the byte edge, 0 for count 0 |

## Verification
The bench builds the unit with its default width of 8 bits and a 3-bit count, which makes the whole space of function codes and counts small enough to cover completely: every count from 0 to 7 is applied under all four codes. For each of those 32 combinations it applies the edge bytes 0x00, 0xFF, 0x01 and 0x80, where fill, zero flag and single-bit carry behaviour stand out, plus a run of random bytes. Each result is compared against a bit-by-bit stepping model, and left shifts by 3 are also checked against multiplication by 8.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_ROL = 2'b10,
    OP_ROR = 2'b11
  } shrot_op_e;

  // Direction in which bits travel: towards the MSB for left operations.
  function automatic logic op_is_left(input shrot_op_e op);
    return (op == OP_SHL) || (op == OP_ROL);
  endfunction

  // Logical shifts discard bits and fill with zero; rotates keep all bits.
  function automatic logic op_is_shift(input shrot_op_e op);
    return (op == OP_SHL) || (op == OP_SHR);
  endfunction

endpackage

// File: rtl/shrot_rotator.sv
// Logarithmic left-rotate network: one stage per bit of the amount.
module shrot_rotator #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] data_o
);

  logic [CNT_W:0][DATA_W-1:0] stage;

  assign stage[0] = data_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    logic [DATA_W-1:0] moved;
    assign moved = {stage[k][DATA_W-1-DIST:0], stage[k][DATA_W-1:DATA_W-DIST]};
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign data_o = stage[CNT_W];

endmodule

// File: rtl/shrot_fill_mask.sv
// Marks which rotated bits survive; vacated positions of a shift are cleared.
module shrot_fill_mask #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  shrot_pkg::shrot_op_e op_i,
  input  logic [CNT_W-1:0]     count_i,
  output logic [DATA_W-1:0]    keep_o
);

  import shrot_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic keep_left;
    logic keep_right;
    // Left shift: position i holds real data once i >= count.
    assign keep_left  = (count_i <= CNT_W'(i));
    // Right shift: position i holds real data while count < DATA_W - i.
    assign keep_right = ({1'b0, count_i} < (CNT_W+1)'(DATA_W - i));

    always_comb begin
      unique case (op_i)
        OP_SHL:  keep_o[i] = keep_left;
        OP_SHR:  keep_o[i] = keep_right;
        default: keep_o[i] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/shrot_flags.sv
// Next zero and carry flag values.
module shrot_flags #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] rotated_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              left_i,
  output logic              zero_o,
  output logic              carry_o
);

  // After a left move by n the last escaping bit lands at position 0 of the
  // rotated word; after a right move it lands at the top position.
  logic edge_bit;

  assign edge_bit = left_i ? rotated_i[0] : rotated_i[DATA_W-1];
  assign carry_o  = (count_i != '0) && edge_bit;
  assign zero_o   = ~|result_i;

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        func_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              carry_o
);

  import shrot_pkg::*;

  shrot_op_e         op;
  logic              left;
  logic [CNT_W-1:0]  rot_amt;
  logic [DATA_W-1:0] rot_w;
  logic [DATA_W-1:0] keep_w;

  assign op   = shrot_op_e'(func_i);
  assign left = op_is_left(op);

  // Right moves by n are left rotations by (DATA_W - n) mod DATA_W.
  assign rot_amt = left ? count_i : (~count_i + CNT_W'(1));

  shrot_rotator #(.DATA_W(DATA_W)) u_rot (
    .data_i (opnd_i),
    .amt_i  (rot_amt),
    .data_o (rot_w)
  );

  shrot_fill_mask #(.DATA_W(DATA_W)) u_mask (
    .op_i    (op),
    .count_i (count_i),
    .keep_o  (keep_w)
  );

  assign result_o = rot_w & keep_w;

  shrot_flags #(.DATA_W(DATA_W)) u_flags (
    .result_i  (result_o),
    .rotated_i (rot_w),
    .count_i   (count_i),
    .left_i    (left),
    .zero_o    (zero_o),
    .carry_o   (carry_o)
  );

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] opnd_i,
  input logic [1:0]        func_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o,
  input logic              carry_o,
  input logic [DATA_W-1:0] rot_w
);

  always_comb begin
    // R5: zero distance is a pass-through with carry cleared
    if (count_i == '0) begin
      a_r5_passthrough: assert (result_o == opnd_i && !carry_o);
    end
    // R6: zero flag tracks the result bits
    a_r6_zero_flag: assert (zero_o == (result_o == '0));
    // R3 / R4: rotates neither lose nor create set bits
    if (func_i[1]) begin
      a_r3_r4_rotate_keeps_bits: assert ($countones(result_o) == $countones(opnd_i));
    end
    // R1 / R2: shifts never add set bits, and the rotator never does either
    if (!func_i[1]) begin
      a_r1_r2_shift_no_growth: assert ($countones(result_o) <= $countones(opnd_i));
    end
    a_r3_rotator_conserves: assert ($countones(rot_w) == $countones(opnd_i));
    // R1: bit 0 is filled with zero on a nonzero left shift
    if (func_i == 2'b00 && count_i != '0) begin
      a_r1_low_fill: assert (result_o[0] == 1'b0);
    end
    // R2: top bit is filled with zero on a nonzero right shift
    if (func_i == 2'b01 && count_i != '0) begin
      a_r2_high_fill: assert (result_o[DATA_W-1] == 1'b0);
    end
    // R8: rotate carry mirrors the wrapped bit in the result
    if (func_i == 2'b10 && count_i != '0) begin
      a_r8_rol_carry: assert (carry_o == result_o[0]);
    end
    if (func_i == 2'b11 && count_i != '0) begin
      a_r8_ror_carry: assert (carry_o == result_o[DATA_W-1]);
    end
  end

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .opnd_i   (opnd_i),
  .func_i   (func_i),
  .count_i  (count_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .carry_o  (carry_o),
  .rot_w    (rot_w)
);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int CNT_W      = 3;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DATA_W-1:0] opnd;
  logic [1:0]        func;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] result;
  logic              zero;
  logic              carry;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  shrot_unit #(.DATA_W(DATA_W)) dut (
    .opnd_i   (opnd),
    .func_i   (func),
    .count_i  (count),
    .result_o (result),
    .zero_o   (zero),
    .carry_o  (carry)
  );

  // Behavioural model: step the byte one place at a time.
  task automatic model(input int a, input int f, input int n,
                       output int r, output int c);
    int v;
    int b;
    v = a;
    c = 0;
    for (int s = 0; s < n; s++) begin
      case (f)
        0: begin b = (v >> 7) & 1; v = (v << 1) & 255; end
        1: begin b = v & 1;        v = v >> 1;         end
        2: begin b = (v >> 7) & 1; v = ((v << 1) | b) & 255; end
        default: begin b = v & 1;  v = (v >> 1) | (b << 7); end
      endcase
      c = b;
    end
    r = v;
  endtask

  task automatic apply(input int a, input int f, input int n);
    int er;
    int ec;
    string rtag;
    string ctag;
    @(posedge clk);
    #1;
    opnd  = DATA_W'(a);
    func  = 2'(f);
    count = CNT_W'(n);
    @(negedge clk);
    model(a, f, n, er, ec);
    case (f)
      0: rtag = "R1";
      1: rtag = "R2";
      2: rtag = "R3";
      default: rtag = "R4";
    endcase
    if (n == 0) begin
      rtag = "R5";
      ctag = "R5";
    end else begin
      ctag = (f < 2) ? "R7" : "R8";
    end
    n_vec++;
    if (int'(result) != er) begin
      n_bad++;
      $display("FAIL %s result op=%0d n=%0d a=%02h actual=%02h expected=%02h",
               rtag, f, n, a, result, er);
    end
    if (zero != (er == 0)) begin
      n_bad++;
      $display("FAIL R6 zero op=%0d n=%0d a=%02h actual=%0b expected=%0b",
               f, n, a, zero, (er == 0));
    end
    if (int'(carry) != ec) begin
      n_bad++;
      $display("FAIL %s carry op=%0d n=%0d a=%02h actual=%0b expected=%0d",
               ctag, f, n, a, carry, ec);
    end
    if (f == 0 && n == 3 && int'(result) != ((a * 8) % 256)) begin
      n_bad++;
      $display("FAIL R9 times-eight a=%02h actual=%02h expected=%02h",
               a, result, (a * 8) % 256);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    opnd  = '0;
    func  = '0;
    count = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: all-zero inputs give a zero byte, zero flag set (R6), no carry (R5).
    @(negedge clk);
    n_vec++;
    if (result != '0 || zero != 1'b1 || carry != 1'b0) begin
      n_bad++;
      $display("FAIL R6 reset-state actual=%02h/%0b/%0b expected=00/1/0",
               result, zero, carry);
    end

    for (int f = 0; f < 4; f++) begin
      for (int n = 0; n < 8; n++) begin
        apply(8'h00, f, n);
        apply(8'hFF, f, n);
        apply(8'h01, f, n);
        apply(8'h80, f, n);
        for (int k = 0; k < 40; k++) begin
          apply(int'($urandom_range(255)), f, n);
        end
      end
    end

    // R9: a dedicated sweep of left shift by 3 over every byte value.
    for (int a = 0; a < 256; a++) begin
      apply(a, 0, 3);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d cycles expected=fewer", WATCHDOG);
      summary();
      $finish;
    end
  end

endmodule